// File: doc/BRIEF.md
# Supply-Fail Access Gate

This controller sits between a host's memory and clock request strobes and the battery-backed storage they drive. Three comparator flags feed it: VCC above the power-fail level, VCC above the switch reference, and battery above the power-fail level. From these flags it decides whether a request may reach the storage. It also chooses whether the backup cell or VCC feeds the storage. Each flag is first brought into the system clock domain through a register chain of `SYNC_STAGES` flops. Every decision is then made from the synchronized values.

Accesses are allowed only while VCC is above the power-fail level, and only once a recovery interval of `REC_CYCLES` clocks has passed since VCC last came back. A write in progress is cut off in the same cycle that the synchronized power-fail flag drops.

The backup cell starts out sealed. It stays disconnected until VCC first rises above the power-fail level, and it stays connected from then on. A mode input selects one of two switchover policies:
- **Higher-voltage supply:** the battery takes over when VCC drops below its own switch point.
- **Lower-voltage supply:** the battery takes over at the power-fail level when the battery sits above that level. Otherwise it takes over when VCC drops below the battery.

Top module: `pwr_gate_top`

## Requirements
- R1: In the cycle after a synchronous reset, `mem_ce_o`, `mem_oe_o`, `mem_we_o`, `access_ok_o`, `bat_link_o` and `sel_battery_o` are all 0.
- R2: While the synchronized power-fail flag is low, or while recovery is still pending, `access_ok_o`, `mem_ce_o` and `mem_we_o` are 0 whatever the requests are.
- R3: `access_ok_o` rises exactly `SYNC_STAGES + REC_CYCLES` clock edges after `vcc_above_pf_i` rises, if the flag stays high for that whole time.
- R4: If the power-fail flag drops before recovery completes, the recovery count restarts from zero on the next rise.
- R5: `mem_we_o` goes to 0 in the same cycle that the synchronized power-fail flag goes low, even when `req_we_i` is still held.
- R6: `bat_link_o` stays 0 until one edge after the synchronized power-fail flag is first high. After that it stays 1 until reset, including while VCC is low.
- R7: While `bat_link_o` is 0, `sel_battery_o` is 0 for every flag combination.
- R8: With `low_volt_sel_i` = 0, `sel_battery_o` equals `bat_link_o` AND NOT (synchronized `vcc_above_sw_i`).
- R9: With `low_volt_sel_i` = 1 and the synchronized `bat_above_pf_i` = 1, `sel_battery_o` equals `bat_link_o` AND NOT (synchronized `vcc_above_pf_i`).
- R10: With `low_volt_sel_i` = 1 and the synchronized `bat_above_pf_i` = 0, `sel_battery_o` equals `bat_link_o` AND NOT (synchronized `vcc_above_sw_i`). In this mode, `vcc_above_sw_i` means VCC is above the battery.
- R11: While `access_ok_o` is 1, the request strobes pass straight through as follows:
  - `mem_ce_o` = `req_ce_i`
  - `mem_we_o` = `req_ce_i` AND `req_we_i`
  - `mem_oe_o` = `req_ce_i` AND `req_oe_i` AND NOT `req_we_i`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vcc_above_pf_i | input | 1 | Comparator: VCC above power-fail level (asynchronous) |
| vcc_above_sw_i | input | 1 | Comparator: VCC above switch reference (asynchronous) |
| bat_above_pf_i | input | 1 | Comparator: battery above power-fail level (asynchronous) |
| low_volt_sel_i | input | 1 | Policy select: 0 = higher-voltage supply, 1 = lower-voltage supply (static) |
| req_ce_i | input | 1 | Host chip-select request, active high |
| req_oe_i | input | 1 | Host read-enable request, active high |
| req_we_i | input | 1 | Host write-enable request, active high |
| mem_ce_o | output | 1 | Gated chip select to storage |
| mem_oe_o | output | 1 | Gated read enable to storage |
| mem_we_o | output | 1 | Gated write enable to storage |
| access_ok_o | output | 1 | Accesses currently permitted |
| bat_link_o | output | 1 | Backup cell connected (seal broken) |
| sel_battery_o | output | 1 | Storage supply taken from the backup cell |

## Verification
The supply policy is driven from a table of flag combinations for each mode. The rows are chosen so that the two policies disagree on some of them. For example, in the lower-voltage mode, VCC can be above the switch reference yet below the power-fail level while the battery sits above that level. That row separates R9 from R8.

Further rows flip only the battery flag, which shows whether the lower-voltage mode consults it. Recovery is timed one edge before and one edge on its expected end, both from a clean rise and after an interrupted count, so an off-by-one error or a count that does not restart is visible.

The write cut is sampled on the edge before and the edge on which the synchronized flag falls. The seal is observed before and after the first power-up, with the flags set so that battery selection is requested.

// File: rtl/pwr_gate_pkg.sv
// Package: shared flag indices and policy encoding for the supply-fail gate.
// Assumes three comparator flags, packed into one vector in the index order below.
package pwr_gate_pkg;

    localparam int FLG_PF    = 0;   // VCC above power-fail level
    localparam int FLG_SW    = 1;   // VCC above switch reference
    localparam int FLG_BAT   = 2;   // battery above power-fail level
    localparam int NUM_FLAGS = 3;

    typedef enum logic {
        POL_HIGH_V = 1'b0,          // switch on the dedicated switch point
        POL_LOW_V  = 1'b1           // switch at power-fail or battery level
    } policy_e;

endpackage

// File: rtl/pwr_flag_sync.sv
// Module: brings asynchronous comparator flags into the clock domain.
// Each flag passes through a chain of STAGES flops. Reset clears every stage,
// which models supplies that are taken as low at power-on.
module pwr_flag_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture raw comparator levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= raw_i;
                end
            end else begin : g_next
                // shift the flags one stage further down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_recovery_timer.sv
// Module: holds off access for REC_CYCLES clocks after the power-fail flag rises.
// Assumes pf_ok_i is already synchronized. A drop of the flag clears the count,
// so every rise starts a full interval.
module pwr_recovery_timer #(
    parameter int REC_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok_i,
    output logic ready_o
);

    localparam int CNT_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ready_q;

    // count good-supply cycles until the recovery interval is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!pf_ok_i) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (cnt_q == LAST) ready_q <= 1'b1;
            else               cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign ready_o = ready_q;

    // R4: a dropped flag leaves the timer idle and cleared
    p_drop_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        !pf_ok_i |=> (!ready_q && cnt_q == '0));

    // R3: ready only ever rises while the supply was good
    p_rise_needs_pf_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(pf_ok_i));

endmodule

// File: rtl/pwr_supply_select.sv
// Module: one-time battery seal plus supply switchover policy.
// The seal opens on the first cycle the synchronized power-fail flag is high,
// and only reset closes it again. The policy input is treated as static.
module pwr_supply_select
    import pwr_gate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  policy_e policy_i,
    input  logic    pf_ok_i,
    input  logic    sw_ok_i,
    input  logic    bat_pf_i,
    output logic    bat_link_o,
    output logic    sel_battery_o
);

    logic link_q;
    logic want_bat;

    // break the freshness seal at the first valid power-up
    always_ff @(posedge clk) begin
        if (!rst_n)       link_q <= 1'b0;
        else if (pf_ok_i) link_q <= 1'b1;
    end

    // pick the switchover condition for the selected supply variant
    always_comb begin
        unique case (policy_i)
            POL_HIGH_V: want_bat = !sw_ok_i;
            POL_LOW_V:  want_bat = bat_pf_i ? !pf_ok_i : !sw_ok_i;
            default:    want_bat = 1'b0;
        endcase
    end

    assign bat_link_o    = link_q;
    assign sel_battery_o = link_q & want_bat;

    // R6: once connected, the backup cell stays connected
    p_link_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        link_q |=> link_q);

    // R7: a sealed cell is never selected
    p_sealed_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !link_q |-> !sel_battery_o);

endmodule

// File: rtl/pwr_gate_top.sv
// Module: supply-fail access gate top level.
// Synchronizes the comparator flags, runs the recovery timer and the supply
// selector, and gates the host strobes. The write strobe is combinational
// from the synchronized flag, so it is cut in the same cycle the fail is seen.
module pwr_gate_top
    import pwr_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REC_CYCLES  = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_pf_i,
    input  logic vcc_above_sw_i,
    input  logic bat_above_pf_i,
    input  logic low_volt_sel_i,
    input  logic req_ce_i,
    input  logic req_oe_i,
    input  logic req_we_i,
    output logic mem_ce_o,
    output logic mem_oe_o,
    output logic mem_we_o,
    output logic access_ok_o,
    output logic bat_link_o,
    output logic sel_battery_o
);

    logic [NUM_FLAGS-1:0] flags_raw;
    logic [NUM_FLAGS-1:0] flags_s;
    logic                 ready;
    logic                 allow;

    assign flags_raw[FLG_PF]  = vcc_above_pf_i;
    assign flags_raw[FLG_SW]  = vcc_above_sw_i;
    assign flags_raw[FLG_BAT] = bat_above_pf_i;

    pwr_flag_sync #(
        .WIDTH  (NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (flags_raw),
        .sync_o (flags_s)
    );

    pwr_recovery_timer #(
        .REC_CYCLES (REC_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_ok_i (flags_s[FLG_PF]),
        .ready_o (ready)
    );

    pwr_supply_select u_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .policy_i      (policy_e'(low_volt_sel_i)),
        .pf_ok_i       (flags_s[FLG_PF]),
        .sw_ok_i       (flags_s[FLG_SW]),
        .bat_pf_i      (flags_s[FLG_BAT]),
        .bat_link_o    (bat_link_o),
        .sel_battery_o (sel_battery_o)
    );

    // combine live supply state with the recovery hold-off
    always_comb begin
        allow = flags_s[FLG_PF] & ready;
    end

    assign access_ok_o = allow;
    assign mem_ce_o    = req_ce_i & allow;
    assign mem_we_o    = req_ce_i & req_we_i & allow;
    assign mem_oe_o    = req_ce_i & req_oe_i & ~req_we_i & allow;

    // R5: no write strobe while the synchronized supply flag is low
    p_we_cut_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !flags_s[FLG_PF] |-> !mem_we_o);

    // R2: any strobe implies the recovery timer has finished
    p_strobe_needs_ready_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_o || mem_we_o || mem_oe_o) |-> ready);

endmodule

// File: tb/pwr_gate_top_bench.sv
module pwr_gate_top_bench;

    localparam int SYNC = 2;
    localparam int REC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf = 1'b0, sw = 1'b0, bat = 1'b0, mode = 1'b0;
    logic ce = 1'b0, oe = 1'b0, we = 1'b0;
    logic mce, moe, mwe, aok, blink, sbat;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_gate_top #(.SYNC_STAGES(SYNC), .REC_CYCLES(REC)) u_pwr_gate_top (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_pf_i(pf), .vcc_above_sw_i(sw), .bat_above_pf_i(bat),
        .low_volt_sel_i(mode),
        .req_ce_i(ce), .req_oe_i(oe), .req_we_i(we),
        .mem_ce_o(mce), .mem_oe_o(moe), .mem_we_o(mwe),
        .access_ok_o(aok), .bat_link_o(blink), .sel_battery_o(sbat)
    );

    // vector bits: {mode, pf, sw, bat, expected sel_battery}
    localparam logic [4:0] VEC [9] = '{
        5'b0_1_1_1_0, 5'b0_1_0_1_1, 5'b0_0_1_0_0, 5'b0_0_0_0_1,
        5'b1_0_1_1_1, 5'b1_1_0_1_0, 5'b1_0_1_0_0, 5'b1_0_0_0_1,
        5'b1_1_1_0_0
    };

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // wait n rising edges, then settle on the following falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        ce = 1'b1; we = 1'b1;
        edges(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 mem_ce", mce, 1'b0);
        chk("R1 mem_we", mwe, 1'b0);
        chk("R1 access_ok", aok, 1'b0);
        chk("R1 bat_link", blink, 1'b0);
        chk("R1 sel_battery", sbat, 1'b0);

        // R7: battery wanted by flags but cell still sealed
        edges(SYNC + 1);
        chk("R7 sealed sel", sbat, 1'b0);

        // R6, R3: first power-up
        pf = 1'b1; sw = 1'b1; bat = 1'b1;
        edges(SYNC - 1);
        chk("R6 seal before", blink, 1'b0);
        edges(1);
        chk("R6 seal still closed on sync edge", blink, 1'b0);
        edges(1);
        chk("R6 seal open", blink, 1'b1);
        edges(REC - 2);
        chk("R3 one edge early", aok, 1'b0);
        chk("R2 we held in recovery", mwe, 1'b0);
        edges(1);
        chk("R3 on time", aok, 1'b1);
        chk("R11 ce pass", mce, 1'b1);
        chk("R11 we pass", mwe, 1'b1);
        chk("R11 oe off in write", moe, 1'b0);
        we = 1'b0; oe = 1'b1;
        #1;
        chk("R11 oe pass", moe, 1'b1);
        chk("R11 we off", mwe, 1'b0);

        // R5: write cut on the edge where the sync flag falls
        we = 1'b1; oe = 1'b0;
        pf = 1'b0;
        edges(SYNC - 1);
        chk("R5 before cut", mwe, 1'b1);
        edges(1);
        chk("R5 cut", mwe, 1'b0);
        chk("R2 access off", aok, 1'b0);
        chk("R6 seal kept", blink, 1'b1);

        // R4: interrupted recovery restarts from zero
        pf = 1'b1;
        edges(SYNC + 4);
        chk("R2 partial recovery", aok, 1'b0);
        pf = 1'b0;
        edges(4);
        pf = 1'b1;
        edges(SYNC + REC - 1);
        chk("R4 restart early", aok, 1'b0);
        edges(1);
        chk("R4 restart on time", aok, 1'b1);

        // R8, R9, R10: supply policy table
        for (int i = 0; i < 9; i++) begin
            string tag;
            {mode, pf, sw, bat} = VEC[i][4:1];
            edges(SYNC);
            tag = (VEC[i][4] == 1'b0) ? "R8" : (VEC[i][1] ? "R9" : "R10");
            chk($sformatf("%s row %0d sel", tag, i), sbat, VEC[i][0]);
            if (!VEC[i][3]) chk($sformatf("R2 row %0d access", i), aok, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule